// File: doc/BRIEF.md
# Signed-Digit Quotient Converter and Rounder

This block sits behind a radix-4 divider iteration stage. Each cycle the stage delivers two signed quotient digits in the range -3..3, and this block turns them into plain binary as they arrive. It keeps a pair of shift registers that always hold the partial quotient and the partial quotient minus one. When the last digit pair is in, a single finish strobe brings the sign and zero status of the final remainder, the rounding mode and the sign of the result.

In that finish cycle the block chooses the decremented copy when the remainder is negative. It then normalises by the leading bit of the quotient and derives guard, round and sticky bits for single or double precision. It rounds to IEEE-754 rules and registers the result. A carry out of the rounded mantissa renormalises it and raises an exponent-adjust flag. Exponent arithmetic, special operands and the iteration itself belong to neighbouring blocks.

Top module: `quo_round`

## Requirements
- R1: `dig_hi` and `dig_lo` are 3-bit two's complement digits in -3..3, and `dig_hi` is the more significant digit of the pair. The code 3'b100 is never applied while `dig_valid` is high.
- R2: `start` clears the accumulated quotient. Each cycle with `dig_valid` appends both digits, so that after n digits the quotient is the integer sum of d_i*4^(n-1-i).
- R3: When `rem_neg` is high at `fin`, the quotient used for rounding is the accumulated value minus one unit of the last digit position.
- R4: The quotient word is 4*pairs bits wide. `hi_norm` is 1 when its top bit is set. Otherwise the word is shifted left by one before the mantissa is taken.
- R5: `dbl_sel`, sampled with `start`, selects the precision. 1 selects double: 14 digit pairs and a 53-bit mantissa on `mant[52:0]`. 0 selects single: 7 pairs and a 24-bit mantissa on `mant[23:0]`, with the upper bits 0. The leading mantissa bit is always 1.
- R6: `rmode` uses 00 for nearest-even, 01 for toward zero, 10 for toward +infinity and 11 for toward -infinity. `res_sign` is 1 for a negative result.
- R7: `inexact` is 1 when any bit below the mantissa is 1 or when `rem_zero` is 0.
- R8: When rounding carries out of the mantissa, `mant` becomes 1 followed by zeros and `exp_inc` is 1.
- R9: The outputs update only at the edge where `fin` is high. `res_valid` is high for exactly the following cycle. After reset every output is 0.
- R10: `fin` is applied only after the full pair count for the selected precision, and never together with `dig_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new quotient |
| dbl_sel | input | 1 | Precision select, taken with start |
| dig_valid | input | 1 | A digit pair is present |
| dig_hi | input | 3 | More significant digit |
| dig_lo | input | 3 | Less significant digit |
| fin | input | 1 | Last pair has been delivered; round now |
| rem_neg | input | 1 | Final remainder is negative |
| rem_zero | input | 1 | Remainder after sign correction is zero |
| rmode | input | 2 | Rounding mode |
| res_sign | input | 1 | Sign of the quotient |
| res_valid | output | 1 | Result present |
| mant | output | 53 | Rounded mantissa |
| hi_norm | output | 1 | Quotient was at least one |
| exp_inc | output | 1 | Rounding overflowed the mantissa |
| inexact | output | 1 | Result is inexact |

## Verification
The assertions assume legal digit codes and a `fin` that follows exactly the pair count for the latched precision. They also assume that the corrected quotient lies between a quarter and the full span of the quotient word. The stimulus always starts with a digit of 2 or 3, which holds the quotient at or above a quarter of the span even after a correction. It also always sends the exact pair count before a lone `fin` cycle. Random digit streams are mixed with directed streams built from chosen bit patterns. These directed streams cover ties, all-ones overflow and the smallest legal quotient.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  // increment decision from lsb, guard, round, sticky
  function automatic logic rnd_inc(rmode_e m, logic sgn, logic lsb,
                                   logic g, logic r, logic s);
    case (m)
      RM_NEAR: return g & (r | s | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return (g | r | s) & ~sgn;
      default: return (g | r | s) & sgn;
    endcase
  endfunction
endpackage

// File: rtl/qdr_otf.sv
module qdr_otf #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [2:0]   d_hi,
  input  logic [2:0]   d_lo,
  output logic [W-1:0] q,
  output logic [W-1:0] qm
);
  typedef struct packed {
    logic [W-1:0] v;
    logic [W-1:0] vm;
  } acc_t;

  // append one signed digit to both the value and value-minus-one
  function automatic acc_t step(acc_t s, logic [2:0] d);
    acc_t n;
    logic [1:0] lo_m;
    lo_m = d[1:0] - 2'd1;
    n.v  = d[2]                  ? {s.vm[W-3:0], d[1:0]} : {s.v[W-3:0], d[1:0]};
    n.vm = (!d[2] && d != 3'd0)  ? {s.v[W-3:0], lo_m}    : {s.vm[W-3:0], lo_m};
    return n;
  endfunction

  acc_t cur, mid, nxt;
  assign cur = '{v: q, vm: qm};
  assign mid = step(cur, d_hi);
  assign nxt = step(mid, d_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      qm <= '1;
    end else if (clr) begin
      q  <= '0;
      qm <= '1;
    end else if (adv) begin
      q  <= nxt.v;
      qm <= nxt.vm;
    end
  end

  // R2: the two registers always differ by exactly one
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q - qm) == W'(1));
endmodule

// File: rtl/qdr_round.sv
module qdr_round
  import qdr_pkg::*;
#(
  parameter int WD = 56,
  parameter int WS = 28,
  parameter int PD = 53,
  parameter int PS = 24
) (
  input  logic          dbl,
  input  logic [WD-1:0] q,
  input  logic [WD-1:0] qm,
  input  logic          rem_neg,
  input  logic          rem_zero,
  input  logic [1:0]    rmode,
  input  logic          sgn,
  output logic [PD-1:0] mant,
  output logic          ovf,
  output logic          inex,
  output logic          top
);
  localparam int GI_D = WD - 1 - PD;
  localparam int GI_S = WD - 1 - PS;
  localparam logic [PD-1:0] LEAD_D = PD'(1) << (PD - 1);
  localparam logic [PD-1:0] LEAD_S = PD'(1) << (PS - 1);

  logic [WD-1:0] qc, qa, nq, sh, smask;
  logic [PD:0]   sum;
  logic [PD-1:0] m;
  logic          g, r, s, inc;
  int            gi;

  assign qc  = rem_neg ? qm : q;
  assign qa  = dbl ? qc : (qc << (WD - WS));
  assign top = qa[WD-1];
  assign nq  = top ? qa : (qa << 1);

  always_comb begin
    gi    = dbl ? GI_D : GI_S;
    g     = nq[gi];
    r     = nq[gi-1];
    smask = (WD'(1) << (gi - 1)) - WD'(1);
    s     = (|(nq & smask)) | ~rem_zero;
    sh    = nq >> (gi + 1);
    m     = sh[PD-1:0];
    inc   = rnd_inc(rmode_e'(rmode), sgn, m[0], g, r, s);
    sum   = {1'b0, m} + (PD+1)'(inc);
    ovf   = dbl ? sum[PD] : sum[PS];
    mant  = ovf ? (dbl ? LEAD_D : LEAD_S) : sum[PD-1:0];
    inex  = g | r | s;
  end
endmodule

// File: rtl/quo_round.sv
module quo_round
  import qdr_pkg::*;
#(
  parameter int PD = 53,
  parameter int PS = 24,
  parameter int EXTRA = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbl_sel,
  input  logic          dig_valid,
  input  logic [2:0]    dig_hi,
  input  logic [2:0]    dig_lo,
  input  logic          fin,
  input  logic          rem_neg,
  input  logic          rem_zero,
  input  logic [1:0]    rmode,
  input  logic          res_sign,
  output logic          res_valid,
  output logic [PD-1:0] mant,
  output logic          hi_norm,
  output logic          exp_inc,
  output logic          inexact
);
  localparam int PAIRS_D = (PD + EXTRA + 3) / 4;
  localparam int PAIRS_S = (PS + EXTRA + 3) / 4;
  localparam int WD      = 4 * PAIRS_D;
  localparam int WS      = 4 * PAIRS_S;
  localparam int CW      = $clog2(PAIRS_D + 1);

  logic          dbl_q;
  logic [CW-1:0] cnt, need;
  logic [WD-1:0] q, qm;
  logic [PD-1:0] r_mant;
  logic          r_ovf, r_inex, r_top;

  assign need = dbl_q ? CW'(PAIRS_D) : CW'(PAIRS_S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      dbl_q <= dbl_sel;
      cnt   <= '0;
    end else if (dig_valid) begin
      cnt   <= cnt + CW'(1);
    end
  end

  qdr_otf #(.W(WD)) u_otf (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(dig_valid),
    .d_hi(dig_hi), .d_lo(dig_lo), .q(q), .qm(qm)
  );

  qdr_round #(.WD(WD), .WS(WS), .PD(PD), .PS(PS)) u_rnd (
    .dbl(dbl_q), .q(q), .qm(qm), .rem_neg(rem_neg), .rem_zero(rem_zero),
    .rmode(rmode), .sgn(res_sign), .mant(r_mant), .ovf(r_ovf),
    .inex(r_inex), .top(r_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      mant      <= '0;
      hi_norm   <= 1'b0;
      exp_inc   <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        mant    <= r_mant;
        hi_norm <= r_top;
        exp_inc <= r_ovf;
        inexact <= r_inex;
      end
    end
  end

  p_digit_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (dig_hi != 3'b100 && dig_lo != 3'b100));
  p_fin_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (cnt == need && !dig_valid));
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(fin)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(mant) && $stable(exp_inc) && $stable(inexact));
  p_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rmode == RM_ZERO) |=> !exp_inc);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !rem_zero) |=> inexact);
  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && exp_inc) |-> ($onehot(mant) && inexact));
  p_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (dbl_q ? mant[PD-1] : (mant[PS-1] && mant[PD-1:PS] == '0)));
endmodule

// File: tb/sim_quo_round.sv
`timescale 1ns/1ps
module sim_quo_round;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dbl_sel = 0, dig_valid = 0, fin = 0;
  logic [2:0] dig_hi = 0, dig_lo = 0;
  logic rem_neg = 0, rem_zero = 1, res_sign = 0;
  logic [1:0] rmode = 0;
  logic res_valid, hi_norm, exp_inc, inexact;
  logic [52:0] mant;

  int checks = 0, fails = 0, cyc = 0;
  int dg [28];

  always #4 clk = ~clk;

  quo_round u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl_sel(dbl_sel),
    .dig_valid(dig_valid), .dig_hi(dig_hi), .dig_lo(dig_lo), .fin(fin),
    .rem_neg(rem_neg), .rem_zero(rem_zero), .rmode(rmode), .res_sign(res_sign),
    .res_valid(res_valid), .mant(mant), .hi_norm(hi_norm),
    .exp_inc(exp_inc), .inexact(inexact)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: compare the discarded tail against a half unit
  function automatic void ref_round(input logic [63:0] qv, input int w, input int p,
      input bit rz, input int mode, input bit sg, output logic [63:0] em,
      output bit eovf, output bit einx, output bit etop);
    logic [63:0] rest, half;
    int sa;
    bit up;
    etop = qv[w-1];
    if (!etop) qv = qv << 1;
    sa   = w - p;
    rest = qv & ((64'd1 << sa) - 1);
    half = 64'd1 << (sa - 1);
    em   = (qv >> sa) & ((64'd1 << p) - 1);
    einx = !(rest == 0 && rz);
    case (mode)
      0: up = (rest > half) || (rest == half && (!rz || em[0]));
      1: up = 0;
      2: up = einx && !sg;
      default: up = einx && sg;
    endcase
    em   = em + (up ? 64'd1 : 64'd0);
    eovf = (em == (64'd1 << p));
    if (eovf) em = 64'd1 << (p - 1);
  endfunction

  task automatic run(bit dbl, bit rn, bit rz, int mode, bit sg, string tag);
    int np = dbl ? 14 : 7;
    int w = 8 * np;
    logic [63:0] qv = 0, em;
    bit eovf, einx, etop;
    w = 4 * np;
    for (int i = 0; i < 2 * np; i++) qv = qv * 4 + 64'(longint'(dg[i]));
    if (rn) qv = qv - 1;
    ref_round(qv, w, dbl ? 53 : 24, rz, mode, sg, em, eovf, einx, etop);
    @(negedge clk); start = 1; dbl_sel = dbl;
    @(negedge clk); start = 0;
    for (int i = 0; i < np; i++) begin
      dig_valid = 1; dig_hi = 3'(dg[2*i]); dig_lo = 3'(dg[2*i+1]);
      @(negedge clk);
    end
    dig_valid = 0;
    fin = 1; rem_neg = rn; rem_zero = rz; rmode = 2'(mode); res_sign = sg;
    @(negedge clk); fin = 0;
    chk({tag, " R9 valid"}, 64'(res_valid), 64'd1);
    chk({tag, " R2 R3 R5 R6 mant"}, 64'(mant), em);
    chk({tag, " R8 exp_inc"}, 64'(exp_inc), 64'(eovf));
    chk({tag, " R7 inexact"}, 64'(inexact), 64'(einx));
    chk({tag, " R4 hi_norm"}, 64'(hi_norm), 64'(etop));
  endtask

  // digits from a bit pattern, 2 bits per digit, most significant first
  task automatic from_bits(logic [63:0] v, int nd);
    for (int i = 0; i < nd; i++) dg[i] = int'((v >> (2 * (nd - 1 - i))) & 3);
  endtask

  initial begin
    logic [52:0] held;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 64'(res_valid), 0);
    chk("R9 reset mant", 64'(mant), 0);
    chk("R9 reset flags", {61'd0, hi_norm, exp_inc, inexact}, 0);
    rst_n = 1;
    @(negedge clk);

    // all threes: maximal quotient, nearest rounds up and carries
    for (int i = 0; i < 28; i++) dg[i] = 3;
    run(1, 0, 1, 0, 0, "dbl all3 near");
    run(1, 0, 1, 1, 0, "dbl all3 zero");
    run(0, 0, 1, 0, 1, "sgl all3 near");
    run(0, 0, 1, 3, 1, "sgl all3 down-neg");
    run(0, 0, 1, 3, 0, "sgl all3 down-pos");
    // output holds when no fin follows
    held = mant;
    @(negedge clk);
    chk("R9 hold valid", 64'(res_valid), 0);
    chk("R9 hold mant", 64'(mant), 64'(held));
    // ties for nearest-even, double: 3 tail bits 100
    from_bits((64'd1 << 55) | 64'd4, 28);
    run(1, 0, 1, 0, 0, "tie even R6");
    run(1, 0, 0, 0, 0, "tie sticky R7");
    from_bits((64'd1 << 55) | 64'd12, 28);
    run(1, 0, 1, 0, 0, "tie odd R6");
    run(1, 0, 1, 2, 0, "exact up R6");
    // smallest legal quotient, with and without correction
    dg[0] = 2;
    for (int i = 1; i < 28; i++) dg[i] = -3;
    run(1, 0, 1, 0, 0, "low dbl R4");
    run(1, 1, 1, 2, 0, "low dbl corr R3");
    run(0, 1, 1, 0, 0, "low sgl corr R3");
    // signed digit mix where corrections reach across many bits
    dg[0] = 3;
    for (int i = 1; i < 28; i++) dg[i] = (i % 2) ? -1 : 1;
    run(1, 1, 0, 3, 1, "mix neg R1");

    for (int t = 0; t < 300; t++) begin
      bit dbl = $urandom_range(0, 1) == 1;
      dg[0] = $urandom_range(2, 3);
      for (int i = 1; i < 28; i++) dg[i] = int'($urandom_range(0, 6)) - 3;
      run(dbl, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
          int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1, "rand R1 R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule